// File: doc/BRIEF.md
# Dual-Channel Converter Output Stage

This block is the digital back end of a two-channel sampling converter. Two 10-bit straight-binary sample words, one per channel, enter together on every rising clock edge. They travel through a fixed five-cycle alignment pipeline and land in a pair of output registers. On the way, each word can be recoded into two's complement by a run-time select. Both channels always move in lockstep.

Three controls shape the output side. An active-low output enable decides whether the two buses are driven. A per-bus drive flag stands in for a high-impedance state. A sleep input and a power-down input each stop sample intake and freeze the output registers at their last word. Power-down has priority if both are raised. When the block returns to run mode, the pipeline must refill before any new word is presented. A data-valid flag marks each cycle in which a fresh word was loaded.

Top module: `dual_adc_out_ctrl`

## Requirements
- R1: With `fmt_twos` low at the loading edge, each bus carries the input sample unchanged (offset binary: 0x000 is negative full scale, 0x200 is mid-scale, 0x3FF is positive full scale minus one step).
- R2: With `fmt_twos` high at the loading edge, bit 9 of the word is inverted and bits 8:0 pass unchanged, so 0x000→0x200, 0x200→0x000 and 0x3FF→0x1FF.
- R3: A sample pair presented at active rising edge N appears on both buses together, after edge N+5, when every edge from N to N+5 is active.
- R4: The format applied to a word is the value of `fmt_twos` at the edge that loads it. Toggling the select every cycle gives each word exactly one format.
- R5: After each edge, `drive_a` and `drive_b` equal the inverse of `oe_n` at that edge. `oe_n` has no effect on bus contents or on `valid`.
- R6: At an edge where `pwrdn` is high, no sample is taken, both buses keep their value and `valid` goes low.
- R7: At an edge where `sleep` is high, no sample is taken, both buses keep their value and `valid` goes low.
- R8: After a release from sleep or power-down, the first active edge is edge N. `valid` stays low and the buses hold through edge N+4. After edge N+5 the buses carry the sample taken at edge N.
- R9: `valid` is high after an edge exactly when that edge loaded a fresh word. The buses change only on such edges.
- R10: After a reset edge the buses are 0x000, and `valid`, `drive_a` and `drive_b` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| samp_a | input | 10 | Channel A sample, straight binary |
| samp_b | input | 10 | Channel B sample, straight binary |
| fmt_twos | input | 1 | 1 selects two's complement, 0 selects offset binary |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Stop sample intake and hold outputs |
| pwrdn | input | 1 | Power-down, holds outputs and has priority over sleep |
| bus_a | output | 10 | Channel A output word |
| bus_b | output | 10 | Channel B output word |
| drive_a | output | 1 | Channel A bus driven (0 models high impedance) |
| drive_b | output | 1 | Channel B bus driven (0 models high impedance) |
| valid | output | 1 | A fresh word was loaded at the last edge |

## Verification
A corrupted fill counter shows at the ports within one refill window. `valid` then rises one or more cycles early or late after a wake-up, and the buses show a stale or mis-aligned pair that the scoreboard catches on the first word it compares. A stage of the alignment line that shifts while halted, or fails to shift while running, puts the wrong sample on the bus five cycles later. A format or drive flag latched at the wrong time is wrong at the very next edge, because both are compared on every cycle.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_PDN   = 2'd2
  } run_mode_e;

endpackage

// File: rtl/sample_delay.sv
module sample_delay #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  // Stage 0 captures the input; each later stage follows its neighbour.
  genvar s;
  generate
    for (s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= '0;
        end else if (shift_en) begin
          if (s == 0) stage_q[s] <= din;
          else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
  import adc_out_pkg::*;
#(
  parameter int LATENCY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  input  logic pwrdn,
  output logic shift_en,
  output logic load_en
);

  localparam int CW = $clog2(LATENCY + 1);

  run_mode_e      mode;
  logic [CW-1:0]  fill_q;
  logic           full;

  // Power-down wins over sleep.
  always_comb begin
    if (pwrdn)      mode = MODE_PDN;
    else if (sleep) mode = MODE_SLEEP;
    else            mode = MODE_RUN;
  end

  assign full     = (fill_q == CW'(LATENCY));
  assign shift_en = (mode == MODE_RUN);
  assign load_en  = shift_en && full;

  // Counts active edges since the last wake-up, saturating at LATENCY.
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (mode != MODE_RUN) begin
      fill_q <= '0;
    end else if (!full) begin
      fill_q <= fill_q + CW'(1);
    end
  end

endmodule

// File: rtl/fmt_encode.sv
module fmt_encode #(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] raw,
  input  logic             twos,
  output logic [WIDTH-1:0] coded
);

  assign coded = {raw[WIDTH-1] ^ twos, raw[WIDTH-2:0]};

endmodule

// File: rtl/dual_adc_out_ctrl.sv
module dual_adc_out_ctrl #(
  parameter int WIDTH   = 10,
  parameter int LATENCY = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] samp_a,
  input  logic [WIDTH-1:0] samp_b,
  input  logic             fmt_twos,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic             pwrdn,
  output logic [WIDTH-1:0] bus_a,
  output logic [WIDTH-1:0] bus_b,
  output logic             drive_a,
  output logic             drive_b,
  output logic             valid
);

  localparam int NCH = 2;

  logic             shift_en;
  logic             load_en;
  logic [WIDTH-1:0] samp_in  [NCH];
  logic [WIDTH-1:0] aligned  [NCH];
  logic [WIDTH-1:0] coded    [NCH];
  logic [WIDTH-1:0] word_q   [NCH];
  logic [NCH-1:0]   drive_q;
  logic             valid_q;

  assign samp_in[0] = samp_a;
  assign samp_in[1] = samp_b;

  run_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .pwrdn    (pwrdn),
    .shift_en (shift_en),
    .load_en  (load_en)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      sample_delay #(.WIDTH(WIDTH), .DEPTH(LATENCY)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (samp_in[c]),
        .dout     (aligned[c])
      );

      fmt_encode #(.WIDTH(WIDTH)) u_fmt (
        .raw   (aligned[c]),
        .twos  (fmt_twos),
        .coded (coded[c])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          word_q[c]  <= '0;
          drive_q[c] <= 1'b0;
        end else begin
          drive_q[c] <= !oe_n;
          if (load_en) word_q[c] <= coded[c];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= load_en;
  end

  assign bus_a   = word_q[0];
  assign bus_b   = word_q[1];
  assign drive_a = drive_q[0];
  assign drive_b = drive_q[1];
  assign valid   = valid_q;

endmodule

// File: rtl/dual_adc_out_ctrl_chk.sv
module dual_adc_out_ctrl_chk #(
  parameter int WIDTH = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             oe_n,
  input logic             sleep,
  input logic             pwrdn,
  input logic [WIDTH-1:0] bus_a,
  input logic [WIDTH-1:0] bus_b,
  input logic             drive_a,
  input logic             drive_b,
  input logic             valid
);

  assert_drive_on_R5: assert property (@(posedge clk) disable iff (rst)
    !oe_n |=> (drive_a && drive_b));

  assert_drive_off_R5: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (!drive_a && !drive_b));

  assert_pdn_hold_R6: assert property (@(posedge clk) disable iff (rst)
    pwrdn |=> ($stable(bus_a) && $stable(bus_b) && !valid));

  assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(bus_a) && $stable(bus_b) && !valid));

  assert_hold_unless_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(bus_a) && $stable(bus_b)));

endmodule

bind dual_adc_out_ctrl dual_adc_out_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .oe_n    (oe_n),
  .sleep   (sleep),
  .pwrdn   (pwrdn),
  .bus_a   (bus_a),
  .bus_b   (bus_b),
  .drive_a (drive_a),
  .drive_b (drive_b),
  .valid   (valid)
);

// File: tb/sim_dual_adc_out_ctrl.sv
`timescale 1ns/1ps
module sim_dual_adc_out_ctrl;

  localparam int W   = 10;
  localparam int LAT = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] samp_a = '0;
  logic [W-1:0] samp_b = '0;
  logic         fmt_twos = 1'b0;
  logic         oe_n = 1'b0;
  logic         sleep = 1'b0;
  logic         pwrdn = 1'b0;
  logic [W-1:0] bus_a, bus_b;
  logic         drive_a, drive_b, valid;

  always #2 clk = ~clk;

  dual_adc_out_ctrl #(.WIDTH(W), .LATENCY(LAT)) u0 (
    .clk(clk), .rst(rst), .samp_a(samp_a), .samp_b(samp_b),
    .fmt_twos(fmt_twos), .oe_n(oe_n), .sleep(sleep), .pwrdn(pwrdn),
    .bus_a(bus_a), .bus_b(bus_b), .drive_a(drive_a), .drive_b(drive_b),
    .valid(valid)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string phase   = "R10";
  bit    started = 1'b0;

  // Reference model built from the requirements.
  logic [2*W-1:0] fresh_q [$];
  logic [W-1:0]   exp_a = '0, exp_b = '0;
  logic           exp_valid = 1'b0, exp_drive = 1'b0;

  function automatic logic [W-1:0] recode(logic [W-1:0] v, logic t);
    return t ? (v ^ 10'h200) : v;
  endfunction

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      fresh_q.delete();
      exp_a = '0; exp_b = '0; exp_valid = 1'b0; exp_drive = 1'b0;
    end else begin
      exp_drive = !oe_n;
      if (pwrdn || sleep) begin
        fresh_q.delete();
        exp_valid = 1'b0;
      end else begin
        fresh_q.push_back({samp_a, samp_b});
        if (fresh_q.size() > LAT) begin
          logic [2*W-1:0] w;
          w = fresh_q.pop_front();
          exp_a = recode(w[2*W-1:W], fmt_twos);
          exp_b = recode(w[W-1:0], fmt_twos);
          exp_valid = 1'b1;
        end else begin
          exp_valid = 1'b0;
        end
      end
    end
  end

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, expv, $time);
    end
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      check(phase, "bus_a", bus_a, exp_a);
      check(phase, "bus_b", bus_b, exp_b);
      check((phase == "R8" || phase == "R10") ? phase : "R9", "valid",
            W'(valid), W'(exp_valid));
      check((phase == "R10") ? "R10" : "R5", "drive_a", W'(drive_a), W'(exp_drive));
      check((phase == "R10") ? "R10" : "R5", "drive_b", W'(drive_b), W'(exp_drive));
    end
  end

  // Driver: changes inputs just after the edge so they are stable at the next.
  task automatic step(logic [W-1:0] a, logic [W-1:0] b, logic t, logic oen,
                      logic slp, logic pd);
    @(posedge clk); #1;
    samp_a = a; samp_b = b; fmt_twos = t; oe_n = oen; sleep = slp; pwrdn = pd;
  endtask

  task automatic run_random(int n, logic t, bit toggle_fmt, bit toggle_oe);
    for (int i = 0; i < n; i++) begin
      step(W'($urandom), W'($urandom), toggle_fmt ? logic'(i[0]) : t,
           toggle_oe ? logic'($urandom_range(0, 1)) : 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic run_corners(logic t);
    step(10'h000, 10'h3FF, t, 1'b0, 1'b0, 1'b0);
    step(10'h200, 10'h000, t, 1'b0, 1'b0, 1'b0);
    step(10'h3FF, 10'h200, t, 1'b0, 1'b0, 1'b0);
    step(10'h1FF, 10'h201, t, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < LAT + 2; i++) step(10'h155, 10'h2AA, t, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    phase = "R10";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    phase = "R1";  run_corners(1'b0); run_random(20, 1'b0, 1'b0, 1'b0);
    phase = "R2";  run_corners(1'b1); run_random(20, 1'b1, 1'b0, 1'b0);
    phase = "R4";  run_random(30, 1'b0, 1'b1, 1'b0);
    phase = "R5";  run_random(30, 1'b0, 1'b0, 1'b1);

    phase = "R6";
    for (int i = 0; i < 8; i++) step(W'($urandom), W'($urandom), 1'b0, 1'b0, 1'b0, 1'b1);
    phase = "R8";  run_random(12, 1'b1, 1'b0, 1'b0);

    phase = "R7";
    for (int i = 0; i < 8; i++) step(W'($urandom), W'($urandom), 1'b1, 1'b0, 1'b1, 1'b0);
    phase = "R8";  run_random(3, 1'b0, 1'b0, 1'b0);

    phase = "R6";
    for (int i = 0; i < 6; i++) step(W'($urandom), W'($urandom), 1'b0, 1'b1, 1'b1, 1'b1);
    phase = "R8";  run_random(12, 1'b0, 1'b0, 1'b0);

    phase = "R3";  run_random(200, 1'b0, 1'b1, 1'b1);
    @(posedge clk);
    @(negedge clk);
    #1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule